// File: doc/BRIEF.md
# Full-Scan Test Application Sequencer

This block drives a single-chain full-scan circuit under test through a complete manufacturing test. It controls the scan-enable line, the serial scan-in bit, the primary inputs and a clock-enable that advances the circuit under test. It observes the primary outputs and the serial scan-out. Each test vector arrives over a ready/valid load port from an on-chip pattern memory. A vector holds a primary-input word, a state word to be scanned in, an expected primary-output word, an expected captured-state word, and a care mask for each expected word.

A run starts with a chain-integrity flush. The sequencer then handles each vector in turn: it scans in the state word, applies the inputs and checks the outputs, and takes one functional capture cycle. The response captured for one vector is scanned out and compared while the next vector's state is scanned in. The last response is unloaded with zero fill. When the run ends, the block raises done and reports pass/fail, the number of mismatching bits and the first failing vector. Chain length, port widths and vector count are parameters.

Top module: `scan_test_seq`

## Requirements
- R1: While reset is held and after its release, done, pass, scan_en and cut_ce are low, and no test activity occurs until a start pulse arrives.
- R2: A run opens with CHAIN_LEN+4 shift cycles. During them scan_in carries the stream 0,0,1,1 followed by CHAIN_LEN zeros. In the last four of those cycles, scan_out is compared against 0,0,1,1. A flush mismatch is reported with first_fail equal to NUM_VEC.
- R3: For each vector there are CHAIN_LEN active cycles with scan_en high, then exactly one active cycle with scan_en low. In that capture cycle cut_pi equals the vector's input word and cut_po is compared against the expected output word.
- R4: The state word is sent most significant bit first, so bit j ends in chain stage j (stage 0 is next to scan_in). While vector i+1 is shifted in, scan_out is compared bit by bit against the expected captured state of vector i, starting with bit CHAIN_LEN-1.
- R5: After the last capture, CHAIN_LEN more shift cycles unload the final response with scan_in held at 0. That response is compared and any mismatch is charged to vector NUM_VEC-1.
- R6: An expected bit whose mask bit is 0 is never counted as a mismatch, whatever the observed value.
- R7: Over a run, cut_ce is high for exactly (NUM_VEC+1)·CHAIN_LEN + NUM_VEC + CHAIN_LEN + 4 cycles. Of these, CHAIN_LEN+4 + (NUM_VEC+1)·CHAIN_LEN have scan_en high.
- R8: If no vector is buffered when one is needed, the sequencer waits with cut_ce and scan_en low. The circuit under test sees no extra clock and the cycle counts of R7 are unchanged.
- R9: At the end, done stays high until the next start. mismatch_cnt is the total number of mismatching compared bits, pass is high only if that count is zero, and first_fail names the earliest failing vector (NUM_VEC for the flush).
- R10: A start pulse while done is high clears the previous results and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| vec_valid | input | 1 | Load port: vector valid |
| vec_ready | output | 1 | Load port: sequencer can accept a vector |
| vec_pi | input | PI_W | Primary-input word of the vector |
| vec_state | input | CHAIN_LEN | State word to scan in |
| vec_exp_po | input | PO_W | Expected primary outputs |
| vec_po_mask | input | PO_W | Care mask for expected outputs |
| vec_exp_state | input | CHAIN_LEN | Expected captured state |
| vec_state_mask | input | CHAIN_LEN | Care mask for captured state |
| cut_ce | output | 1 | Clock enable for the circuit under test |
| scan_en | output | 1 | Test control: 1 shift, 0 functional capture |
| scan_in | output | 1 | Serial chain input |
| cut_pi | output | PI_W | Primary inputs to the circuit under test |
| cut_po | input | PO_W | Primary outputs from the circuit under test |
| scan_out | input | 1 | Serial chain output |
| done | output | 1 | Run complete |
| pass | output | 1 | Run complete with no mismatch |
| mismatch_cnt | output | MW | Count of mismatching compared bits |
| first_fail | output | VW | Index of first failing vector, NUM_VEC for flush |

## Verification
The bench runs random vectors through a behavioural scan circuit with nonlinear next-state and output functions. Because of those functions, a wrong bit order, a misplaced capture or a wrong input word shows up as a mismatch. Single flipped expectations are placed in an output word, in a mid-run captured state and in the final unloaded state; the resulting counts and first-failure indices tell apart the capture-time compare, the overlapped shift-out compare and the trailing unload. Masked flips check don't-care handling. A scan output stuck at zero exercises the flush and yields a computed mismatch total. Random gaps on the load port check that waiting neither clocks the circuit nor changes the cycle totals.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FLUSH  = 3'd1,
    PH_WAITV  = 3'd2,
    PH_SHIFT  = 3'd3,
    PH_CAPT   = 3'd4,
    PH_UNLOAD = 3'd5,
    PH_DONE   = 3'd6
  } phase_e;

  // Number of header bits shifted ahead of the fill during the flush.
  localparam int FLUSH_HEAD = 4;
endpackage

// File: rtl/scan_seq_stage.sv
module scan_seq_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  output logic          full,
  output logic [DW-1:0] data
);
  logic          full_d;
  logic          load_en;
  logic [DW-1:0] data_q;

  assign in_ready = !full;
  assign load_en  = in_valid && !full;

  always_comb begin
    full_d = full;
    if (load_en)   full_d = 1'b1;
    else if (pop)  full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full <= 1'b0;
    else        full <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= in_data;
  end

  assign data = data_q;
endmodule

// File: rtl/scan_seq_score.sv
module scan_seq_score #(
  parameter int W   = 4,
  parameter int MW  = 8,
  parameter int VW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          chk_en,
  input  logic [W-1:0]  chk_exp,
  input  logic [W-1:0]  chk_act,
  input  logic [W-1:0]  chk_mask,
  input  logic [VW-1:0] chk_idx,
  output logic [MW-1:0] miss_cnt,
  output logic          any_fail,
  output logic [VW-1:0] first_idx
);
  logic [W-1:0]  miss_bits;
  logic [MW-1:0] miss_add;
  logic [MW-1:0] cnt_d;
  logic          fail_d;
  logic [VW-1:0] first_d;

  // R6: masked positions never contribute.
  assign miss_bits = (chk_exp ^ chk_act) & chk_mask;

  always_comb begin
    miss_add = '0;
    for (int b = 0; b < W; b++) miss_add = miss_add + MW'(miss_bits[b]);
  end

  always_comb begin
    cnt_d   = miss_cnt;
    fail_d  = any_fail;
    first_d = first_idx;
    if (clr) begin
      cnt_d   = '0;
      fail_d  = 1'b0;
      first_d = '0;
    end else if (chk_en) begin
      cnt_d = miss_cnt + miss_add;
      if (|miss_bits && !any_fail) begin
        fail_d  = 1'b1;
        first_d = chk_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_cnt  <= '0;
      any_fail  <= 1'b0;
      first_idx <= '0;
    end else begin
      miss_cnt  <= cnt_d;
      any_fail  <= fail_d;
      first_idx <= first_d;
    end
  end
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter int PO_W      = 4,
  parameter int NUM_VEC   = 6,
  localparam int CW       = $clog2(CHAIN_LEN + FLUSH_HEAD),
  localparam int VW       = $clog2(NUM_VEC + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 s_full,
  input  logic [PI_W-1:0]      s_pi,
  input  logic [CHAIN_LEN-1:0] s_st,
  input  logic [PO_W-1:0]      s_epo,
  input  logic [PO_W-1:0]      s_pmask,
  input  logic [CHAIN_LEN-1:0] s_est,
  input  logic [CHAIN_LEN-1:0] s_smask,
  output logic                 take,
  output logic                 clr,
  output logic                 cut_ce,
  output logic                 scan_en,
  output logic                 scan_in,
  output logic [PI_W-1:0]      cut_pi,
  input  logic [PO_W-1:0]      cut_po,
  input  logic                 scan_out,
  output logic                 done,
  output logic                 chk_en,
  output logic [PO_W-1:0]      chk_exp,
  output logic [PO_W-1:0]      chk_act,
  output logic [PO_W-1:0]      chk_mask,
  output logic [VW-1:0]        chk_idx
);
  localparam logic [CW-1:0] C_M       = CW'(CHAIN_LEN);
  localparam logic [CW-1:0] C_M_LAST  = CW'(CHAIN_LEN - 1);
  localparam logic [CW-1:0] C_FL_LAST = CW'(CHAIN_LEN + FLUSH_HEAD - 1);
  localparam logic [CW-1:0] C_HI_FROM = CW'(2);
  localparam logic [CW-1:0] C_HI_TO   = CW'(3);
  localparam logic [CW-1:0] C_CMP_HI  = CW'(CHAIN_LEN + 2);
  localparam logic [VW-1:0] V_LAST    = VW'(NUM_VEC - 1);
  localparam logic [VW-1:0] V_FLUSH   = VW'(NUM_VEC);

  phase_e                phase_q, phase_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [VW-1:0]         vidx_q, vidx_d;
  logic [PI_W-1:0]       wpi_q;
  logic [CHAIN_LEN-1:0]  wst_q;
  logic [PO_W-1:0]       wepo_q, wpmask_q;
  logic [CHAIN_LEN-1:0]  west_q, wsmask_q;
  logic [CHAIN_LEN-1:0]  pest_q, psmask_q;
  logic [VW-1:0]         pidx_q;
  logic                  shift_work, shift_prev, copy_prev;

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    vidx_d  = vidx_q;
    take    = 1'b0;
    clr     = 1'b0;
    unique case (phase_q)
      PH_IDLE, PH_DONE: begin
        if (start) begin          // R10: restart clears results
          phase_d = PH_FLUSH;
          cnt_d   = '0;
          vidx_d  = '0;
          clr     = 1'b1;
        end
      end
      PH_FLUSH: begin
        if (cnt_q == C_FL_LAST) begin
          cnt_d = '0;
          if (s_full) begin
            take    = 1'b1;
            phase_d = PH_SHIFT;
          end else begin
            phase_d = PH_WAITV;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WAITV: begin             // R8: hold the circuit still
        if (s_full) begin
          take    = 1'b1;
          cnt_d   = '0;
          phase_d = PH_SHIFT;
        end
      end
      PH_SHIFT: begin
        if (cnt_q == C_M_LAST) begin
          cnt_d   = '0;
          phase_d = PH_CAPT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CAPT: begin
        vidx_d = vidx_q + 1'b1;
        cnt_d  = '0;
        if (vidx_q == V_LAST) begin
          phase_d = PH_UNLOAD;
        end else if (s_full) begin
          take    = 1'b1;
          phase_d = PH_SHIFT;
        end else begin
          phase_d = PH_WAITV;
        end
      end
      PH_UNLOAD: begin
        if (cnt_q == C_M_LAST) phase_d = PH_DONE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      vidx_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      vidx_q  <= vidx_d;
    end
  end

  // Clock enables for the data registers
  assign shift_work = (phase_q == PH_SHIFT);
  assign shift_prev = (phase_q == PH_SHIFT) || (phase_q == PH_UNLOAD);
  assign copy_prev  = (phase_q == PH_CAPT);

  // Working vector: R4 state word leaves MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpi_q    <= '0;
      wst_q    <= '0;
      wepo_q   <= '0;
      wpmask_q <= '0;
      west_q   <= '0;
      wsmask_q <= '0;
    end else if (take) begin
      wpi_q    <= s_pi;
      wst_q    <= s_st;
      wepo_q   <= s_epo;
      wpmask_q <= s_pmask;
      west_q   <= s_est;
      wsmask_q <= s_smask;
    end else if (shift_work) begin
      wst_q <= wst_q << 1;
    end
  end

  // Expected response of the previous vector, unloaded during next shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pest_q   <= '0;
      psmask_q <= '0;
      pidx_q   <= '0;
    end else if (copy_prev) begin
      pest_q   <= west_q;
      psmask_q <= wsmask_q;
      pidx_q   <= vidx_q;
    end else if (shift_prev) begin
      pest_q   <= pest_q << 1;
      psmask_q <= psmask_q << 1;
    end
  end

  // Outputs to the circuit under test
  always_comb begin
    cut_ce  = 1'b0;
    scan_en = 1'b0;
    scan_in = 1'b0;
    unique case (phase_q)
      PH_FLUSH: begin           // R2: 0,0,1,1 then zero fill
        cut_ce  = 1'b1;
        scan_en = 1'b1;
        scan_in = (cnt_q >= C_HI_FROM) && (cnt_q <= C_HI_TO);
      end
      PH_SHIFT: begin
        cut_ce  = 1'b1;
        scan_en = 1'b1;
        scan_in = wst_q[CHAIN_LEN-1];
      end
      PH_CAPT: begin            // R3: functional capture
        cut_ce  = 1'b1;
      end
      PH_UNLOAD: begin          // R5: zero fill
        cut_ce  = 1'b1;
        scan_en = 1'b1;
      end
      default: ;
    endcase
  end

  assign cut_pi = wpi_q;
  assign done   = (phase_q == PH_DONE);

  // Compare bus to the scoreboard
  always_comb begin
    chk_en   = 1'b0;
    chk_exp  = '0;
    chk_act  = '0;
    chk_mask = '0;
    chk_idx  = pidx_q;
    unique case (phase_q)
      PH_FLUSH: begin
        chk_en      = (cnt_q >= C_M);
        chk_exp[0]  = (cnt_q >= C_CMP_HI);
        chk_act[0]  = scan_out;
        chk_mask[0] = 1'b1;
        chk_idx     = V_FLUSH;
      end
      PH_SHIFT, PH_UNLOAD: begin
        chk_en      = (phase_q == PH_UNLOAD) || (vidx_q != '0);
        chk_exp[0]  = pest_q[CHAIN_LEN-1];
        chk_act[0]  = scan_out;
        chk_mask[0] = psmask_q[CHAIN_LEN-1];
      end
      PH_CAPT: begin
        chk_en   = 1'b1;
        chk_exp  = wepo_q;
        chk_act  = cut_po;
        chk_mask = wpmask_q;
        chk_idx  = vidx_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
  parameter int CHAIN_LEN = 8,
  parameter int PI_W      = 4,
  parameter int PO_W      = 4,
  parameter int NUM_VEC   = 6,
  localparam int VW       = $clog2(NUM_VEC + 1),
  localparam int MISS_MAX = 4 + NUM_VEC * (PO_W + CHAIN_LEN),
  localparam int MW       = $clog2(MISS_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 vec_valid,
  output logic                 vec_ready,
  input  logic [PI_W-1:0]      vec_pi,
  input  logic [CHAIN_LEN-1:0] vec_state,
  input  logic [PO_W-1:0]      vec_exp_po,
  input  logic [PO_W-1:0]      vec_po_mask,
  input  logic [CHAIN_LEN-1:0] vec_exp_state,
  input  logic [CHAIN_LEN-1:0] vec_state_mask,
  output logic                 cut_ce,
  output logic                 scan_en,
  output logic                 scan_in,
  output logic [PI_W-1:0]      cut_pi,
  input  logic [PO_W-1:0]      cut_po,
  input  logic                 scan_out,
  output logic                 done,
  output logic                 pass,
  output logic [MW-1:0]        mismatch_cnt,
  output logic [VW-1:0]        first_fail
);
  localparam int DW = PI_W + 3 * CHAIN_LEN + 2 * PO_W;

  logic [1:0]           rst_sync;
  logic                 rst_int_n;
  logic [DW-1:0]        in_pack, st_pack;
  logic                 s_full, take, clr;
  logic [PI_W-1:0]      s_pi;
  logic [CHAIN_LEN-1:0] s_st, s_est, s_smask;
  logic [PO_W-1:0]      s_epo, s_pmask;
  logic                 chk_en, any_fail;
  logic [PO_W-1:0]      chk_exp, chk_act, chk_mask;
  logic [VW-1:0]        chk_idx;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign in_pack = {vec_pi, vec_state, vec_exp_po, vec_po_mask,
                    vec_exp_state, vec_state_mask};
  assign {s_pi, s_st, s_epo, s_pmask, s_est, s_smask} = st_pack;

  scan_seq_stage #(.DW(DW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_valid (vec_valid),
    .in_ready (vec_ready),
    .in_data  (in_pack),
    .pop      (take),
    .full     (s_full),
    .data     (st_pack)
  );

  scan_seq_ctrl #(
    .CHAIN_LEN (CHAIN_LEN),
    .PI_W      (PI_W),
    .PO_W      (PO_W),
    .NUM_VEC   (NUM_VEC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .s_full   (s_full),
    .s_pi     (s_pi),
    .s_st     (s_st),
    .s_epo    (s_epo),
    .s_pmask  (s_pmask),
    .s_est    (s_est),
    .s_smask  (s_smask),
    .take     (take),
    .clr      (clr),
    .cut_ce   (cut_ce),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .cut_pi   (cut_pi),
    .cut_po   (cut_po),
    .scan_out (scan_out),
    .done     (done),
    .chk_en   (chk_en),
    .chk_exp  (chk_exp),
    .chk_act  (chk_act),
    .chk_mask (chk_mask),
    .chk_idx  (chk_idx)
  );

  scan_seq_score #(.W(PO_W), .MW(MW), .VW(VW)) u_score (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .chk_en    (chk_en),
    .chk_exp   (chk_exp),
    .chk_act   (chk_act),
    .chk_mask  (chk_mask),
    .chk_idx   (chk_idx),
    .miss_cnt  (mismatch_cnt),
    .any_fail  (any_fail),
    .first_idx (first_fail)
  );

  // R9: pass only meaningful once done
  assign pass = done && !any_fail;
endmodule

// File: rtl/scan_test_seq_chk.sv
module scan_test_seq_chk #(
  parameter int CHAIN_LEN = 8,
  parameter int NUM_VEC   = 6,
  parameter int MW        = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cut_ce,
  input logic          scan_en,
  input logic          done,
  input logic          pass,
  input logic [MW-1:0] mismatch_cnt
);
  localparam int TOTAL = (NUM_VEC + 1) * CHAIN_LEN + NUM_VEC + CHAIN_LEN + 4;

  int ce_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ce_cnt <= 0;
    else if (done)   ce_cnt <= 0;
    else if (cut_ce) ce_cnt <= ce_cnt + 1;
  end

  assert_single_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_ce && !scan_en) |=> !(cut_ce && !scan_en));

  assert_no_shift_when_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> cut_ce);

  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cut_ce);

  assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && mismatch_cnt == '0));

  assert_fail_reported_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mismatch_cnt != '0) |-> !pass);

  assert_cycle_total_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (ce_cnt == TOTAL));
endmodule

bind scan_test_seq scan_test_seq_chk #(
  .CHAIN_LEN (CHAIN_LEN),
  .NUM_VEC   (NUM_VEC),
  .MW        (MW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cut_ce       (cut_ce),
  .scan_en      (scan_en),
  .done         (done),
  .pass         (pass),
  .mismatch_cnt (mismatch_cnt)
);

// File: tb/scan_test_seq_test.sv
module scan_test_seq_test;
  localparam int M    = 8;
  localparam int PIW  = 4;
  localparam int POW  = 4;
  localparam int N    = 6;
  localparam int VW   = $clog2(N + 1);
  localparam int MW   = $clog2(4 + N * (POW + M) + 1);
  localparam int TOTAL_CE = (N + 1) * M + N + M + 4;
  localparam int TOTAL_SE = (N + 1) * M + M + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [PIW-1:0] vec_pi = '0;
  logic [M-1:0]   vec_state = '0, vec_exp_state = '0, vec_state_mask = '0;
  logic [POW-1:0] vec_exp_po = '0, vec_po_mask = '0;
  logic cut_ce, scan_en, scan_in, scan_out, done, pass;
  logic [PIW-1:0] cut_pi;
  logic [POW-1:0] cut_po;
  logic [MW-1:0]  mismatch_cnt;
  logic [VW-1:0]  first_fail;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  // Pattern memory
  logic [PIW-1:0] mpi  [N];
  logic [M-1:0]   mst  [N];
  logic [POW-1:0] mepo [N];
  logic [POW-1:0] mpm  [N];
  logic [M-1:0]   mest [N];
  logic [M-1:0]   msm  [N];

  // Behavioural circuit under test
  logic [M-1:0] cut_st;
  logic stuck_chain = 1'b0;

  function automatic logic [M-1:0] f_next(input logic [PIW-1:0] p, input logic [M-1:0] s);
    logic [M-1:0] r;
    for (int j = 0; j < M; j++)
      r[j] = s[(j + M - 1) % M] ^ p[j % PIW] ^ (s[(j + 2) % M] & s[(j + 5) % M]);
    return r;
  endfunction

  function automatic logic [POW-1:0] f_po(input logic [PIW-1:0] p, input logic [M-1:0] s);
    logic [POW-1:0] r;
    for (int j = 0; j < POW; j++)
      r[j] = s[j] ^ (s[j + 4] & p[(j + 1) % PIW]) ^ p[j];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (cut_ce) cut_st <= scan_en ? {cut_st[M-2:0], scan_in} : f_next(cut_pi, cut_st);
  end
  assign scan_out = stuck_chain ? 1'b0 : cut_st[M-1];
  assign cut_po   = f_po(cut_pi, cut_st);

  scan_test_seq #(.CHAIN_LEN(M), .PI_W(PIW), .PO_W(POW), .NUM_VEC(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_pi(vec_pi),
    .vec_state(vec_state), .vec_exp_po(vec_exp_po), .vec_po_mask(vec_po_mask),
    .vec_exp_state(vec_exp_state), .vec_state_mask(vec_state_mask),
    .cut_ce(cut_ce), .scan_en(scan_en), .scan_in(scan_in), .cut_pi(cut_pi),
    .cut_po(cut_po), .scan_out(scan_out), .done(done), .pass(pass),
    .mismatch_cnt(mismatch_cnt), .first_fail(first_fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < N; i++) begin
      mpi[i]  = PIW'($urandom);
      mst[i]  = M'($urandom);
      mepo[i] = f_po(mpi[i], mst[i]);
      mest[i] = f_next(mpi[i], mst[i]);
      mpm[i]  = '1;
      msm[i]  = '1;
    end
  endtask

  task automatic feeder(input bit stall);
    for (int i = 0; i < N; i++) begin
      int guard;
      if (stall) repeat ($urandom % 12) @(negedge clk);
      @(negedge clk);
      vec_valid      = 1'b1;
      vec_pi         = mpi[i];
      vec_state      = mst[i];
      vec_exp_po     = mepo[i];
      vec_po_mask    = mpm[i];
      vec_exp_state  = mest[i];
      vec_state_mask = msm[i];
      guard = 0;
      while (!vec_ready && guard < 3000) begin
        @(negedge clk);
        guard++;
      end
      @(negedge clk);
      vec_valid = 1'b0;
    end
  endtask

  // Expected scan_en on the a-th active cycle (R3 ordering)
  function automatic bit exp_se(input int a);
    int b;
    if (a < M + 4) return 1'b1;
    b = a - (M + 4);
    if (b >= N * (M + 1)) return 1'b1;
    return (b % (M + 1)) != M;
  endfunction

  task automatic run_case(input string tag, input bit stall,
                          input int exp_mis, input int exp_first);
    int n_ce, n_se, se_bad, pi_bad, fl_bad, cap, cyc;
    bit timeout;
    n_ce = 0; n_se = 0; se_bad = 0; pi_bad = 0; fl_bad = 0; cap = 0; cyc = 0;
    timeout = 1'b0;
    fork
      feeder(stall);
      begin
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done && !timeout) begin
          if (cut_ce) begin
            if (n_ce < M + 4) begin
              // R2: flush stream 0,0,1,1 then zeros
              if (scan_in !== ((n_ce == 2) || (n_ce == 3))) fl_bad++;
            end
            if (scan_en !== exp_se(n_ce)) se_bad++;
            if (!scan_en) begin
              if (cap < N && cut_pi !== mpi[cap]) pi_bad++;
              cap++;
            end
            n_ce++;
            if (scan_en) n_se++;
          end
          @(negedge clk);
          cyc++;
          if (cyc > 4000) timeout = 1'b1;
        end
      end
    join
    $display("[TB] case %s finished", tag);
    chk(!timeout, "R9", {tag, " done reached"}, int'(done), 1);
    chk(n_ce == TOTAL_CE, "R7", {tag, " cut_ce cycles"}, n_ce, TOTAL_CE);
    chk(n_se == TOTAL_SE, "R7", {tag, " scan_en cycles"}, n_se, TOTAL_SE);
    chk(fl_bad == 0, "R2", {tag, " flush scan_in stream"}, fl_bad, 0);
    chk(se_bad == 0, "R3", {tag, " shift/capture order"}, se_bad, 0);
    chk(pi_bad == 0, "R3", {tag, " inputs at capture"}, pi_bad, 0);
    chk(int'(mismatch_cnt) == exp_mis, "R9", {tag, " mismatch count"},
        int'(mismatch_cnt), exp_mis);
    chk(pass == (exp_mis == 0), "R9", {tag, " pass flag"}, int'(pass), int'(exp_mis == 0));
    if (exp_mis != 0)
      chk(int'(first_fail) == exp_first, "R9", {tag, " first failing index"},
          int'(first_fail), exp_first);
  endtask

  initial begin
    int ones;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!done && !pass && !scan_en && !cut_ce, "R1", "outputs in reset",
        int'({done, pass, scan_en, cut_ce}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && !cut_ce && !scan_en, "R1", "idle after reset",
        int'({done, cut_ce, scan_en}), 0);

    // R4: clean random run, overlapped unload of every response
    fill_random();
    run_case("R4_clean", 1'b0, 0, 0);

    // R3: expected output bit flipped on vector 2
    fill_random();
    mepo[2][1] = ~mepo[2][1];
    run_case("R3_po_flip", 1'b0, 1, 2);

    // R10: restart from done clears old failure
    fill_random();
    run_case("R10_restart", 1'b0, 0, 0);

    // R4/R5: captured-state flips in mid run and in the final unload
    fill_random();
    mest[1][6] = ~mest[1][6];
    mest[N-1][0] = ~mest[N-1][0];
    run_case("R4_R5_state_flip", 1'b0, 2, 1);

    // R5: only final unload wrong
    fill_random();
    mest[N-1][M-1] = ~mest[N-1][M-1];
    run_case("R5_unload_flip", 1'b0, 1, N - 1);

    // R6: flipped but masked bits
    fill_random();
    mest[3][4] = ~mest[3][4];
    msm[3][4]  = 1'b0;
    mepo[0][0] = ~mepo[0][0];
    mpm[0][0]  = 1'b0;
    mest[N-1][2] = ~mest[N-1][2];
    msm[N-1][2]  = 1'b0;
    run_case("R6_masked", 1'b0, 0, 0);

    // R8: random load gaps
    fill_random();
    run_case("R8_stall", 1'b1, 0, 0);
    fill_random();
    mepo[N-1][3] = ~mepo[N-1][3];
    run_case("R8_stall_fail", 1'b1, 1, N - 1);

    // R2: scan output stuck at 0; flush loses the two ones
    fill_random();
    ones = 0;
    for (int i = 0; i < N; i++) ones += $countones(mest[i] & msm[i]);
    stuck_chain = 1'b1;
    run_case("R2_stuck_chain", 1'b0, 2 + ones, N);
    stuck_chain = 1'b0;

    // R9: done holds until next start
    repeat (10) @(negedge clk);
    chk(done && !cut_ce, "R9", "done held while idle", int'({done, cut_ce}), 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule